// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by reading one page table entry per level from memory. A walk begins at the first-level table named by the root base input. At each level a slice of the virtual page number picks an entry in the current table. That entry either points to the next table or, at the last level, names the physical page that holds the data. If any entry it reads is marked not present, the walk stops there and a page fault is reported.

A client offers a virtual address on a valid/ready request port. The walker then reads memory through a port with its own request handshake and a response strobe, and it never has more than one read in flight. When the walk ends, it raises a one-cycle done pulse. With the pulse come the fault flag, the level at which the walk ended, the physical page number and the full physical address. The default shape has four levels of 9-bit indices, a 12-bit page offset, 40-bit physical page numbers and 8-byte entries. At the default shape one entry spans 512 GB at level 1, 1 GB at level 2, 2 MB at level 3 and 4 KB at level 4.

Top module: `page_walker`

## Requirements
- R1: The first memory read of a walk uses the table base `root_ppn` as it was sampled when the request was accepted. A later change of `root_ppn` does not affect a walk already in progress.
- R2: The table index for level L (1 = first, 4 = last) is `req_va[12 + 9*(4-L) +: 9]`. Level 1 therefore uses bits 47..39 and level 4 uses bits 20..12.
- R3: Every entry read address equals `{table_base, 12'h000} + index*8`.
- R4: Each entry is 64 bits wide. Bit 0 is the present bit and bits 51..12 hold a 40-bit page number. At levels 1 to 3 that page number becomes the base of the next table.
- R5: A walk in which all four entries are present makes exactly four reads. It ends with `fault`=0, `rsp_ppn` equal to the last entry's page number, `rsp_pa` = {`rsp_ppn`, `req_va[11:0]`} and `end_level`=3.
- R6: An entry with the present bit clear ends the walk at once, with no further read. The walk ends with `fault`=1, and `end_level` gives the 0-based level of that entry, so the number of reads is `end_level`+1.
- R7: `mem_req_addr` stays stable while `mem_req_valid` is high and `mem_req_ready` is low. At most one read is outstanding, and no new read is issued before the pending response arrives.
- R8: `req_ready` is high only while no walk is in progress, and a request is taken only when `req_valid` and `req_ready` are both high.
- R9: A `req_valid` raised during a walk has no effect. The result and the number of reads are those of the walk already in progress.
- R10: `done` is high for exactly one cycle per walk. `fault`, `end_level`, `rsp_ppn` and `rsp_pa` hold their values until the next `done`.
- R11: After reset, `req_ready`=1, `mem_req_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 48 | Virtual address to translate |
| root_ppn | input | 40 | Page number of the first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| end_level | output | 2 | 0-based level of the last entry read |
| rsp_ppn | output | 40 | Translated physical page number |
| rsp_pa | output | 52 | Translated physical address |

## Verification
The hardest case to reach from the ports is a fault on a deep level. It needs three valid entries, each placed where the previous entry's page number points, followed by a non-present entry. To build this, the bench computes the whole chain of entry addresses from the virtual address and the root base, and fills a sparse memory model at those addresses. It then marks one chosen level as not present, and repeats this for each level in turn. Back-pressure and slow responses come from a memory model that delays its response and drops its ready at pseudo-random times. A second request is held on the request port throughout one walk to show that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2
  } walk_state_e;

  localparam int ENTRY_W       = 64;
  localparam int ENTRY_SHIFT   = 3;
  localparam int PRESENT_BIT   = 0;
  localparam int ENTRY_PPN_LSB = 12;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    assign slice[g] = va[OFF_W + IDX_W * (LEVELS - 1 - g) +: IDX_W];
  end

  assign idx = slice[level];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] table_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);
  function automatic logic [PA_W-1:0] form_entry_addr(
    input logic [PPN_W-1:0] base,
    input logic [IDX_W-1:0] index
  );
    logic [PA_W-1:0] base_byte;
    logic [PA_W-1:0] byte_off;
    base_byte = {base, {OFF_W{1'b0}}};
    byte_off  = PA_W'(index) << ENTRY_SHIFT;
    return base_byte + byte_off;
  endfunction

  assign entry_addr = form_entry_addr(table_base, idx);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [PPN_W-1:0]   root_ppn,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  input  logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic [VA_W-1:0]    va_q,
  output logic [LVL_W-1:0]   level_q,
  output logic [PPN_W-1:0]   base_q,
  output logic               done,
  output logic               fault,
  output logic [LVL_W-1:0]   end_level,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PA_W-1:0]    rsp_pa
);
  walk_state_e state_q;

  function automatic logic entry_present(input logic [ENTRY_W-1:0] e);
    return e[PRESENT_BIT];
  endfunction

  function automatic logic [PPN_W-1:0] entry_ppn(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_PPN_LSB +: PPN_W];
  endfunction

  logic walk_start, issue_fire, rsp_take, last_level;
  assign req_ready     = (state_q == W_IDLE);
  assign mem_req_valid = (state_q == W_ISSUE);
  assign walk_start    = req_ready && req_valid;
  assign issue_fire    = mem_req_valid && mem_req_ready;
  assign rsp_take      = (state_q == W_WAIT) && mem_rsp_valid;
  assign last_level    = (level_q == LVL_W'(LEVELS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      va_q      <= '0;
      level_q   <= '0;
      base_q    <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      end_level <= '0;
      rsp_ppn   <= '0;
      rsp_pa    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        W_IDLE: begin
          if (walk_start) begin
            va_q    <= req_va;
            base_q  <= root_ppn;
            level_q <= '0;
            state_q <= W_ISSUE;
          end
        end
        W_ISSUE: begin
          if (issue_fire) state_q <= W_WAIT;
        end
        W_WAIT: begin
          if (rsp_take) begin
            if (!entry_present(mem_rsp_data)) begin
              done      <= 1'b1;
              fault     <= 1'b1;
              end_level <= level_q;
              rsp_ppn   <= '0;
              rsp_pa    <= '0;
              state_q   <= W_IDLE;
            end else if (last_level) begin
              done      <= 1'b1;
              fault     <= 1'b0;
              end_level <= level_q;
              rsp_ppn   <= entry_ppn(mem_rsp_data);
              rsp_pa    <= {entry_ppn(mem_rsp_data), va_q[OFF_W-1:0]};
              state_q   <= W_IDLE;
            end else begin
              base_q  <= entry_ppn(mem_rsp_data);
              level_q <= level_q + 1'b1;
              state_q <= W_ISSUE;
            end
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  // Reads in flight, counted from port handshakes alone.
  logic [1:0] inflight_q;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else inflight_q <= inflight_q + {1'b0, issue_fire} - {1'b0, mem_rsp_valid};
  end

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q <= 2'd1) && (mem_rsp_valid -> inflight_q == 2'd1));

  assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || inflight_q != 2'd0) |-> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [PPN_W-1:0]   root_ppn,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               done,
  output logic               fault,
  output logic [LVL_W-1:0]   end_level,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PA_W-1:0]    rsp_pa
);
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] level_q;
  logic [PPN_W-1:0] base_q;
  logic [IDX_W-1:0] cur_idx;

  ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_idx (
    .va(va_q), .level(level_q), .idx(cur_idx)
  );

  ptw_entry_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_addr (
    .table_base(base_q), .idx(cur_idx), .entry_addr(mem_req_addr)
  );

  ptw_ctrl #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .va_q(va_q), .level_q(level_q), .base_q(base_q),
    .done(done), .fault(fault), .end_level(end_level),
    .rsp_ppn(rsp_ppn), .rsp_pa(rsp_pa)
  );
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
  localparam int VA_W = 48;
  localparam int PA_W = 52;
  localparam int PN_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_va = '0;
  logic [PN_W-1:0] root_ppn = '0;
  logic            mem_req_valid, mem_req_ready = 1'b1;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            done, fault;
  logic [1:0]      end_level;
  logic [PN_W-1:0] rsp_ppn;
  logic [PA_W-1:0] rsp_pa;

  page_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_ppn(root_ppn), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .end_level(end_level),
    .rsp_ppn(rsp_ppn), .rsp_pa(rsp_pa)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sparse memory model with pseudo-random back-pressure and latency.
  logic [63:0] pmem [logic [PA_W-1:0]];
  logic [PA_W-1:0] alog [16];
  int   n_reads = 0;
  int   lat = 0;
  bit   stall = 0;
  bit   pend = 0;
  int   cnt = 0;
  logic [PA_W-1:0] paddr = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pmem.exists(paddr) ? pmem[paddr] : 64'h0;
        pend <= 0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      pend  <= 1;
      paddr <= mem_req_addr;
      cnt   <= lat;
      if (n_reads < 16) alog[n_reads] <= mem_req_addr;
      n_reads <= n_reads + 1;
    end
    mem_req_ready <= stall ? lfsr[0] : 1'b1;
  end

  function automatic logic [8:0] idx_of(input logic [VA_W-1:0] va, input int lvl);
    return va[12 + 9 * (3 - lvl) +: 9];
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [PN_W-1:0] b, input logic [8:0] i);
    return {b, 12'h000} + PA_W'(i) * 8;
  endfunction

  logic [PA_W-1:0] exp_addr [4];

  // Build a chain of tables; bad = level (0..3) whose entry is not present, 4 = none.
  task automatic build(input logic [PN_W-1:0] root, input logic [VA_W-1:0] va,
                       input logic [PN_W-1:0] p0, p1, p2, p3, input int bad);
    logic [PN_W-1:0] pn [4];
    logic [PN_W-1:0] b;
    pn[0] = p0; pn[1] = p1; pn[2] = p2; pn[3] = p3;
    pmem.delete();
    b = root;
    for (int l = 0; l < 4; l++) begin
      exp_addr[l] = ent_addr(b, idx_of(va, l));
      pmem[exp_addr[l]] = {12'h000, pn[l], 11'h000, (l == bad) ? 1'b0 : 1'b1};
      b = pn[l];
    end
  endtask

  task automatic start_walk(input logic [PN_W-1:0] root, input logic [VA_W-1:0] va);
    @(negedge clk);
    n_reads   = 0;
    req_valid = 1'b1;
    req_va    = va;
    root_ppn  = root;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic walk_and_check(input string tag, input logic [PN_W-1:0] root,
                                input logic [VA_W-1:0] va, input logic [PN_W-1:0] p0, p1, p2, p3,
                                input int bad);
    int nr;
    build(root, va, p0, p1, p2, p3, bad);
    start_walk(root, va);
    wait_done();
    chk({tag, " done R10"}, done, 1'b1);
    nr = (bad == 4) ? 4 : bad + 1;
    chk({tag, " fault R6"}, fault, (bad != 4));
    chk({tag, " end_level R6"}, end_level, (bad == 4) ? 3 : bad);
    chk({tag, " read count R6"}, n_reads, nr);
    for (int l = 0; l < nr; l++) chk({tag, " entry addr R3"}, alog[l], exp_addr[l]);
    if (bad == 4) begin
      chk({tag, " ppn R5"}, rsp_ppn, p3);
      chk({tag, " pa R5"}, rsp_pa, {p3, va[11:0]});
    end
  endtask

  task automatic t_reset();
    chk("reset req_ready R11", req_ready, 1'b1);
    chk("reset mem_req_valid R11", mem_req_valid, 1'b0);
    chk("reset done R11", done, 1'b0);
  endtask

  task automatic t_basic();
    walk_and_check("basic R1 R2 R4", 40'h00_0000_0100, 48'h1234_5678_9ABC,
                   40'h00_0000_0200, 40'h00_0000_0300, 40'h00_0000_0400, 40'h12_3456_789A, 4);
    chk("first read from root R1", alog[0], ent_addr(40'h100, 9'h024));
  endtask

  task automatic t_faults();
    for (int b = 0; b < 4; b++)
      walk_and_check("fault level R6", 40'h00_0000_0A00, 48'h7FFF_0123_4567,
                     40'h00_0000_0B00, 40'h00_0000_0C00, 40'h00_0000_0D00, 40'h00_0000_0E00, b);
  endtask

  task automatic t_edges();
    walk_and_check("idx all ones R2", 40'hFF_FFFF_F000, 48'hFFFF_FFFF_FFFF,
                   40'h80_0000_0001, 40'h40_0000_0002, 40'h20_0000_0003, 40'hFF_FFFF_FFFF, 4);
    walk_and_check("idx all zero R2", 40'h00_0000_0001, 48'h0000_0000_0000,
                   40'h00_0000_0002, 40'h00_0000_0003, 40'h00_0000_0004, 40'h00_0000_0005, 4);
  endtask

  task automatic t_root_change();
    walk_and_check("root A R1", 40'h00_0000_1000, 48'h0040_2010_0ABC,
                   40'h11, 40'h22, 40'h33, 40'h44, 4);
    walk_and_check("root B R1", 40'h00_0000_5000, 48'h0040_2010_0ABC,
                   40'h55, 40'h66, 40'h77, 40'h88, 4);
  endtask

  task automatic t_stall();
    stall = 1; lat = 3;
    walk_and_check("stall R7", 40'h00_0000_0900, 48'h5555_AAAA_3C3C,
                   40'h901, 40'h902, 40'h903, 40'hABCDE, 4);
    stall = 0; lat = 0;
  endtask

  task automatic t_busy();
    logic [VA_W-1:0] va1 = 48'h0123_4567_8DEF;
    bit seen_ready = 0;
    int t = 0;
    lat = 4;
    build(40'h700, va1, 40'h701, 40'h702, 40'h703, 40'h7_7777, 4);
    start_walk(40'h700, va1);
    req_valid = 1'b1; req_va = 48'hFFFF_0000_FFFF; root_ppn = 40'h999;
    while (!done && t < 3000) begin
      if (req_ready) seen_ready = 1;
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    chk("busy req_ready low R8", seen_ready, 1'b0);
    chk("busy done R9", done, 1'b1);
    chk("busy reads R9", n_reads, 4);
    chk("busy pa R9", rsp_pa, {40'h7_7777, va1[11:0]});
    @(negedge clk);
    chk("pulse single R10", done, 1'b0);
    chk("pulse hold pa R10", rsp_pa, {40'h7_7777, va1[11:0]});
    repeat (10) @(negedge clk);
    chk("no late walk R9", n_reads, 4);
    lat = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_faults();
    t_edges();
    t_root_change();
    t_stall();
    t_busy();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule